// File: doc/BRIEF.md
# NAND Flash Host Bridge

This block sits between a processor's byte-wide memory bus and a raw NAND flash device. Software drives the flash pins through a single mode register, moves bytes through a data port, and watches a small interrupt status/mask pair. The ECC engine and the flash device are outside the block. The bridge only issues strobes to them: one to clear the ECC engine, one to start it and one to read it out.

The bus has two windows. A fixed configuration page holds an enable bit and a relocatable base address. The base is written one byte lane at a time. A 256-byte data window appears at the page selected by that base, but only while the enable bit is set. Every access is a single byte and takes a single cycle. Read data is combinational from the address presented in that cycle.

Top module: `nand_host_bridge`

## Requirements
- R1: After reset, the following hold. The interrupt output is low. The chip-enable pin is high (deselected). The command latch, address latch and write-protect pins are low. The enable bit is clear. The configuration command register reads 0x00, all base bytes read 0x00, and the interrupt status and mask are zero.
- R2: The mode register is at data-window offset 4 and reads back the value last written. In the cycle after a write, the pins follow it: bit 0 drives the command latch pin, bit 1 the address latch pin and bit 7 the write-protect pin. The active-low chip-enable pin carries the inverse of bit 4.
- R3: A write to the mode register pulses ECC strobes in the write cycle only, decoded from bits 6:5. A value of 3 pulses the clear strobe alone. A value of 1 pulses both the start strobe and the clear strobe. A value of 2 pulses the read-out strobe. A value of 0 pulses nothing.
- R4: Data-window offsets 0 to 3 all alias the flash data port. A write there pulses the flash write strobe and drives the written byte on the flash output bus in the same cycle, then sets interrupt status bit 0. A read there returns the flash input bus and pulses the flash read strobe for that one cycle.
- R5: Offset 5 always reads 0x14. Offset 6 is the interrupt status register and offset 7 the interrupt mask register, both byte-wide, readable and writable. Other data-window offsets read 0x00.
- R6: The interrupt output is high exactly when mask bit 7 is set and the AND of mask and status is non-zero. It changes only in the cycle after a write.
- R7: In the configuration page, offset 0x04 is the command register. Written bit 1 sets the enable bit. A read returns 0x02 when enabled and 0x00 otherwise.
- R8: Configuration offsets 0x10 + i (i = 0..3) hold byte lane i (bits 8i+7:8i) of the base address. Each lane is written alone and reads back alone.
- R9: The data window responds only while enabled and when address bits 31:8 equal base bits 31:8. Otherwise a read returns 0x00 and a write changes no state. The configuration page wins if the base points at it.
- R10: Reads change no register state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| fl_din | input | 8 | Byte presented by the flash |
| fl_dout | output | 8 | Byte driven to the flash |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe |
| fl_cle | output | 1 | Command latch enable pin |
| fl_ale | output | 1 | Address latch enable pin |
| fl_ce_n | output | 1 | Chip enable pin, active low |
| fl_wp | output | 1 | Write-protect pin |
| ecc_clr | output | 1 | ECC clear strobe |
| ecc_start | output | 1 | ECC start strobe |
| ecc_rdout | output | 1 | ECC read-out strobe |
| irq | output | 1 | Interrupt output |

## Verification
The bench uses the default parameters: a 32-bit address and the configuration page at page 1. With the full 32-bit address, all four base lanes take part in the compare, so the bench can show that a mismatch in the top lane alone hides the window. Putting the configuration page at 1 lets the bench also move the base onto that same page, which exercises the precedence rule.

// File: rtl/nfb_pkg.sv
package nfb_pkg;
   // configuration page offsets
   localparam logic [7:0] CFG_CMD_OFS  = 8'h04;
   localparam logic [7:0] CFG_BASE_OFS = 8'h10;
   localparam int         CMD_EN_BIT   = 1;
   // data window offsets
   localparam logic [7:0] WIN_MODE_OFS = 8'h04;
   localparam logic [7:0] WIN_STAT_OFS = 8'h05;
   localparam logic [7:0] WIN_ISR_OFS  = 8'h06;
   localparam logic [7:0] WIN_IMR_OFS  = 8'h07;
   localparam logic [7:0] WIN_STAT_VAL = 8'h14;
   // mode bit positions
   localparam int MB_CLE = 0;
   localparam int MB_ALE = 1;
   localparam int MB_CE  = 4;
   localparam int MB_WP  = 7;
   localparam int MASK_MASTER = 7;

   typedef enum logic [1:0] {
      ECC_NONE  = 2'd0,
      ECC_START = 2'd1,
      ECC_READ  = 2'd2,
      ECC_CLEAR = 2'd3
   } ecc_op_e;
endpackage

// File: rtl/nfb_cfg_regs.sv
module nfb_cfg_regs #(
   parameter int ADDR_W = 32,
   localparam int LANES = ADDR_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [7:0]        ofs,
   input  logic [7:0]        wdata,
   output logic              win_en,
   output logic [ADDR_W-1:0] base,
   output logic [7:0]        rdata
);
   import nfb_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         win_en <= 1'b0;
      else if (wr && ofs == CFG_CMD_OFS)  win_en <= wdata[CMD_EN_BIT];
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            base[8*i +: 8] <= 8'h00;
         else if (wr && ofs == CFG_BASE_OFS + 8'(i))
            base[8*i +: 8] <= wdata;
      end
   end

   always_comb begin
      rdata = 8'h00;
      if (ofs == CFG_CMD_OFS) rdata[CMD_EN_BIT] = win_en;
      for (int i = 0; i < LANES; i++)
         if (ofs == CFG_BASE_OFS + 8'(i)) rdata = base[8*i +: 8];
   end
endmodule

// File: rtl/nfb_win_regs.sv
module nfb_win_regs (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic       rd,
   input  logic [7:0] ofs,
   input  logic [7:0] wdata,
   input  logic [7:0] fl_din,
   output logic [7:0] mode_q,
   output logic [7:0] isr_q,
   output logic [7:0] imr_q,
   output logic [7:0] rdata,
   output logic       fl_we,
   output logic       fl_re,
   output logic       ecc_clr,
   output logic       ecc_start,
   output logic       ecc_rdout,
   output logic       irq
);
   import nfb_pkg::*;

   logic    port_hit;
   logic    mode_wr;
   ecc_op_e ecc_op;

   assign port_hit = (ofs[7:2] == 6'd0);
   assign mode_wr  = wr && ofs == WIN_MODE_OFS;
   assign ecc_op   = ecc_op_e'(wdata[6:5]);

   assign fl_we     = wr && port_hit;
   assign fl_re     = rd && port_hit;
   assign ecc_clr   = mode_wr && (ecc_op == ECC_CLEAR || ecc_op == ECC_START);
   assign ecc_start = mode_wr && ecc_op == ECC_START;
   assign ecc_rdout = mode_wr && ecc_op == ECC_READ;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= 8'h00;
         isr_q  <= 8'h00;
         imr_q  <= 8'h00;
      end else if (wr) begin
         if (port_hit)                 isr_q[0] <= 1'b1;
         else if (ofs == WIN_MODE_OFS) mode_q   <= wdata;
         else if (ofs == WIN_ISR_OFS)  isr_q    <= wdata;
         else if (ofs == WIN_IMR_OFS)  imr_q    <= wdata;
      end
   end

   assign irq = imr_q[MASK_MASTER] && |(imr_q & isr_q);

   always_comb begin
      rdata = 8'h00;
      if (port_hit) rdata = fl_din;
      else case (ofs)
         WIN_MODE_OFS: rdata = mode_q;
         WIN_STAT_OFS: rdata = WIN_STAT_VAL;
         WIN_ISR_OFS:  rdata = isr_q;
         WIN_IMR_OFS:  rdata = imr_q;
         default:      rdata = 8'h00;
      endcase
   end
endmodule

// File: rtl/nand_host_bridge.sv
module nand_host_bridge #(
   parameter int ADDR_W   = 32,
   parameter int CFG_PAGE = 1,
   localparam int PAGE_W  = ADDR_W - 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic [7:0]        fl_din,
   output logic [7:0]        fl_dout,
   output logic              fl_we,
   output logic              fl_re,
   output logic              fl_cle,
   output logic              fl_ale,
   output logic              fl_ce_n,
   output logic              fl_wp,
   output logic              ecc_clr,
   output logic              ecc_start,
   output logic              ecc_rdout,
   output logic              irq
);
   import nfb_pkg::*;

   initial begin
      if (ADDR_W % 8 != 0 || ADDR_W < 16 || ADDR_W > 64)
         $fatal(1, "ADDR_W must be a multiple of 8 between 16 and 64");
      if (CFG_PAGE < 0 || CFG_PAGE >= (1 << (PAGE_W > 30 ? 30 : PAGE_W)))
         $fatal(1, "CFG_PAGE does not fit the page field");
   end

   logic [7:0]        ofs;
   logic [PAGE_W-1:0] page;
   logic              cfg_hit, win_hit, win_en;
   logic [ADDR_W-1:0] base;
   logic [7:0]        cfg_rdata, win_rdata;
   logic [7:0]        mode_q, isr_q, imr_q;

   assign ofs     = bus_addr[7:0];
   assign page    = bus_addr[ADDR_W-1:8];
   assign cfg_hit = (page == PAGE_W'(CFG_PAGE));
   assign win_hit = !cfg_hit && win_en && (page == base[ADDR_W-1:8]);

   nfb_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr     (bus_wr && cfg_hit),
      .ofs    (ofs),
      .wdata  (bus_wdata),
      .win_en (win_en),
      .base   (base),
      .rdata  (cfg_rdata)
   );

   nfb_win_regs u_win (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (bus_wr && win_hit),
      .rd        (bus_rd && win_hit),
      .ofs       (ofs),
      .wdata     (bus_wdata),
      .fl_din    (fl_din),
      .mode_q    (mode_q),
      .isr_q     (isr_q),
      .imr_q     (imr_q),
      .rdata     (win_rdata),
      .fl_we     (fl_we),
      .fl_re     (fl_re),
      .ecc_clr   (ecc_clr),
      .ecc_start (ecc_start),
      .ecc_rdout (ecc_rdout),
      .irq       (irq)
   );

   assign bus_rdata = cfg_hit ? cfg_rdata : (win_hit ? win_rdata : 8'h00);
   assign fl_dout   = bus_wdata;
   assign fl_cle    = mode_q[MB_CLE];
   assign fl_ale    = mode_q[MB_ALE];
   assign fl_ce_n   = ~mode_q[MB_CE];
   assign fl_wp     = mode_q[MB_WP];
endmodule

// File: rtl/nand_host_bridge_chk.sv
module nand_host_bridge_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       bus_wr,
   input logic       bus_rd,
   input logic [7:0] bus_wdata,
   input logic [7:0] bus_rdata,
   input logic [7:0] ofs,
   input logic       win_hit,
   input logic [7:0] mode_q,
   input logic [7:0] isr_q,
   input logic [7:0] imr_q,
   input logic       fl_ce_n,
   input logic       fl_we,
   input logic       fl_re,
   input logic       ecc_clr,
   input logic       ecc_start,
   input logic       ecc_rdout,
   input logic       irq
);
   import nfb_pkg::*;

   assert_ce_follows_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && win_hit && ofs == WIN_MODE_OFS) |=> (fl_ce_n == !$past(bus_wdata[MB_CE])));

   assert_start_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ecc_start |-> ecc_clr);

   assert_ecc_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ecc_start, ecc_rdout}) && !(ecc_rdout && ecc_clr));

   assert_data_sets_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fl_we |=> isr_q[0]);

   assert_read_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fl_re |-> (bus_rd && win_hit));

   assert_status_const_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && win_hit && ofs == WIN_STAT_OFS) |-> bus_rdata == WIN_STAT_VAL);

   assert_irq_after_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(irq) |-> $past(bus_wr));

   assert_read_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && !bus_wr) |=> ($stable(mode_q) && $stable(isr_q) && $stable(imr_q)));
endmodule

bind nand_host_bridge nand_host_bridge_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_rd    (bus_rd),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .ofs       (ofs),
   .win_hit   (win_hit),
   .mode_q    (mode_q),
   .isr_q     (isr_q),
   .imr_q     (imr_q),
   .fl_ce_n   (fl_ce_n),
   .fl_we     (fl_we),
   .fl_re     (fl_re),
   .ecc_clr   (ecc_clr),
   .ecc_start (ecc_start),
   .ecc_rdout (ecc_rdout),
   .irq       (irq)
);

// File: tb/tb_nand_host_bridge.sv
module tb_nand_host_bridge;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] bus_addr = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_wdata = '0, fl_din = 8'h00;
   logic [7:0]  bus_rdata, fl_dout;
   logic        fl_we, fl_re, fl_cle, fl_ale, fl_ce_n, fl_wp;
   logic        ecc_clr, ecc_start, ecc_rdout, irq;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;
   logic [2:0] cap_ecc;
   logic       cap_we, cap_re;
   logic [7:0] cap_dout, rd_val;

   localparam logic [31:0] CFG = 32'h0000_0100;
   localparam logic [31:0] WIN = 32'h1234_5600;

   always #10 clk = ~clk;

   nand_host_bridge dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .fl_din(fl_din), .fl_dout(fl_dout), .fl_we(fl_we), .fl_re(fl_re),
      .fl_cle(fl_cle), .fl_ale(fl_ale), .fl_ce_n(fl_ce_n), .fl_wp(fl_wp),
      .ecc_clr(ecc_clr), .ecc_start(ecc_start), .ecc_rdout(ecc_rdout), .irq(irq)
   );

   // mode value, expected {wp,ce_n,ale,cle}, expected {clr,start,rdout}
   typedef struct packed { logic [7:0] mode; logic [3:0] pins; logic [2:0] ecc; } mvec_t;
   localparam mvec_t MV [6] = '{
      '{8'h00, 4'b0100, 3'b000},
      '{8'h13, 4'b0011, 3'b000},
      '{8'h70, 4'b0000, 3'b100},
      '{8'h21, 4'b0101, 3'b110},
      '{8'hC2, 4'b1110, 3'b001},
      '{8'h90, 4'b1000, 3'b000}
   };

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [31:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      #2;
      cap_ecc = {ecc_clr, ecc_start, ecc_rdout};
      cap_we = fl_we; cap_dout = fl_dout;
      @(negedge clk);
      bus_wr = 1'b0;
      #2;
   endtask

   task automatic rd(input logic [31:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #2;
      d = bus_rdata; cap_re = fl_re;
      @(negedge clk);
      bus_rd = 1'b0;
      #2;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #(20 * 150000);
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1 reset state
      chk(irq == 0 && fl_ce_n == 1 && fl_cle == 0 && fl_ale == 0 && fl_wp == 0, "R1 pins",
          {irq, fl_ce_n, fl_cle, fl_ale, fl_wp}, 5'b01000);
      rd(CFG + 32'h04, rd_val); chk(rd_val == 8'h00, "R1 cmd", rd_val, 0);
      rd(CFG + 32'h13, rd_val); chk(rd_val == 8'h00, "R1 base", rd_val, 0);

      // R9 disabled window: write ignored, read zero
      wr(32'h0000_0006, 8'hFF);
      rd(32'h0000_0006, rd_val); chk(rd_val == 8'h00, "R9 disabled read", rd_val, 0);

      // R8 base lanes
      wr(CFG + 32'h10, 8'hAB); wr(CFG + 32'h11, 8'h56);
      wr(CFG + 32'h12, 8'h34); wr(CFG + 32'h13, 8'h12);
      rd(CFG + 32'h10, rd_val); chk(rd_val == 8'hAB, "R8 lane0", rd_val, 8'hAB);
      rd(CFG + 32'h13, rd_val); chk(rd_val == 8'h12, "R8 lane3", rd_val, 8'h12);
      rd(WIN + 32'h05, rd_val); chk(rd_val == 8'h00, "R9 not enabled", rd_val, 0);

      // R7 enable
      wr(CFG + 32'h04, 8'h02);
      rd(CFG + 32'h04, rd_val); chk(rd_val == 8'h02, "R7 enabled", rd_val, 2);
      rd(WIN + 32'h06, rd_val); chk(rd_val == 8'h00, "R9 earlier write ignored", rd_val, 0);
      rd(WIN + 32'h05, rd_val); chk(rd_val == 8'h14, "R5 status", rd_val, 8'h14);
      rd(WIN + 32'h09, rd_val); chk(rd_val == 8'h00, "R5 unused offset", rd_val, 0);
      rd(32'h9234_5605, rd_val); chk(rd_val == 8'h00, "R9 top lane mismatch", rd_val, 0);

      // R2 R3 mode table
      foreach (MV[i]) begin
         wr(WIN + 32'h04, MV[i].mode);
         chk(cap_ecc == MV[i].ecc, "R3 ecc strobes", cap_ecc, MV[i].ecc);
         chk({fl_wp, fl_ce_n, fl_ale, fl_cle} == MV[i].pins, "R2 pins",
             {fl_wp, fl_ce_n, fl_ale, fl_cle}, MV[i].pins);
         chk({ecc_clr, ecc_start, ecc_rdout} == 3'b000, "R3 strobe width",
             {ecc_clr, ecc_start, ecc_rdout}, 0);
         rd(WIN + 32'h04, rd_val); chk(rd_val == MV[i].mode, "R2 readback", rd_val, MV[i].mode);
      end

      // R6 mask without master, R4 data writes through aliases
      wr(WIN + 32'h07, 8'h01);
      wr(WIN + 32'h02, 8'h5A);
      chk(cap_we == 1 && cap_dout == 8'h5A, "R4 write strobe", {cap_we, cap_dout}, 9'h15A);
      rd(WIN + 32'h06, rd_val); chk(rd_val == 8'h01, "R4 done bit", rd_val, 1);
      chk(irq == 0, "R6 no master", irq, 0);
      wr(WIN + 32'h07, 8'h81);
      chk(irq == 1, "R6 master set", irq, 1);
      wr(WIN + 32'h06, 8'h00);
      chk(irq == 0, "R6 status cleared", irq, 0);
      wr(WIN + 32'h07, 8'h80); wr(WIN + 32'h06, 8'h01);
      chk(irq == 0, "R6 no overlap", irq, 0);
      wr(WIN + 32'h06, 8'h80);
      chk(irq == 1, "R6 master bit overlap", irq, 1);
      wr(WIN + 32'h06, 8'h00);

      // R4 reads through each alias, R10 no side effect
      for (int k = 0; k < 4; k++) begin
         fl_din = 8'hC0 + 8'(k);
         rd(WIN + 32'(k), rd_val);
         chk(rd_val == 8'hC0 + 8'(k) && cap_re == 1, "R4 read alias",
             {cap_re, rd_val}, {1'b1, 8'hC0 + 8'(k)});
         chk(fl_re == 0, "R4 read strobe width", fl_re, 0);
      end
      rd(WIN + 32'h06, rd_val); chk(rd_val == 8'h00, "R10 reads leave status", rd_val, 0);

      // R9 precedence: base onto config page
      wr(CFG + 32'h13, 8'h00); wr(CFG + 32'h12, 8'h00); wr(CFG + 32'h11, 8'h01);
      rd(CFG + 32'h04, rd_val); chk(rd_val == 8'h02, "R9 config wins", rd_val, 2);
      wr(CFG + 32'h07, 8'hFF);
      wr(CFG + 32'h11, 8'h56); wr(CFG + 32'h12, 8'h34); wr(CFG + 32'h13, 8'h12);
      rd(WIN + 32'h07, rd_val); chk(rd_val == 8'h80, "R9 shadowed write", rd_val, 8'h80);

      // R7 disable again
      wr(CFG + 32'h04, 8'hFD);
      rd(CFG + 32'h04, rd_val); chk(rd_val == 8'h00, "R7 disabled", rd_val, 0);
      rd(WIN + 32'h07, rd_val); chk(rd_val == 8'h00, "R9 after disable", rd_val, 0);

      finish_run();
   end
endmodule